// File: doc/BRIEF.md
# Modulated Delay Tap Generator

This block turns four slowly moving oscillators into read positions for a modulated delay line. Two of the oscillators produce quadrature sine and cosine values. The other two are sawtooth phase accumulators. Every oscillator is programmed with a rate and an amplitude, and all of them advance by one step on each sample strobe. The block's job ends at a delay offset and an interpolation weight. Memory access and the multiply that uses the weight belong to the surrounding datapath.

The datapath issues a tap query for one oscillator together with a 6-bit modifier. The modifier can do the following:

- choose the cosine output instead of the sine output;
- capture a snapshot of the oscillator so that later queries in the same pass see one consistent value;
- replace the weight with its complement;
- invert the offset bits;
- shift a sawtooth by half its span to give a second pointer for pitch shifting;
- turn a sawtooth into a crossfade gain.

A restart command puts one sawtooth back to its start value without changing its programming.

Top module: `lfo_addr_gen`

## Requirements
- R1: After a synchronous reset, every oscillator has zero state, zero rate and zero amplitude, and every snapshot is zero. `out_valid`, `out_addr` and `out_coef` are 0, and a query with modifier 0 on any oscillator returns offset 0 and weight 0.
- R2: Loading a quadrature oscillator (select 0 or 1) works as follows.
  - The load sets sine to 0 and cosine to 28672 and stores rate `ld_rate[8:0]` and amplitude `ld_amp`.
  - On each sample strobe, sine becomes s + ((c·k) >>> 17), truncated to 16 bits signed.
  - Cosine then becomes c − ((s_new·k) >>> 17), also truncated to 16 bits signed.
- R3: For a quadrature oscillator, let v be the sine value, or the cosine value when modifier bit 0 is set. Let P = v·amplitude.
  - The offset is floor(P / 2^15) as 16-bit two's complement.
  - The weight is (P mod 2^15) >> 7.
- R4: Loading a sawtooth (select 2 or 3) works as follows.
  - The load clears its phase, stores the 16-bit rate `ld_rate` and stores span code `ld_amp[1:0]`.
  - The span is 512, 1024, 2048 or 4096 delay locations for codes 0 to 3. The phase carries 8 fraction bits.
  - On each sample strobe, the phase decreases by the rate, modulo span·256.
- R5: For a sawtooth with no modifier bits set, the offset is phase >> 8 (zero extended) and the weight is phase mod 256.
- R6: Modifier bit 4 on a sawtooth adds half the span to the phase, modulo span·256, before R5 or R7 is applied.
- R7: Modifier bit 5 on a sawtooth forces the offset to 0. The weight becomes min(ph, F − ph)·256 / (F/2), where F = span·256. This gives 0 at the wrap point and 256 at mid-span.
- R8: Modifier bit 2 replaces the weight w with 256 − w.
- R9: Modifier bit 3 inverts every bit of the 16-bit offset, except when bit 5 is set on a sawtooth.
- R10: With modifier bit 1 set, a query uses the live oscillator state and stores that state as the oscillator's snapshot. With bit 1 clear, the query uses the stored snapshot.
- R11: Restart (`jam_valid`, `jam_sel` 0 or 1 for the two sawtooths) clears that sawtooth's phase and keeps its rate and span. On the same oscillator, load takes priority over restart, and restart takes priority over a sample step.
- R12: Modifier bits 4 and 5 have no effect on a quadrature oscillator.
- R13: A query's result appears with `out_valid` high one cycle after `q_valid`. A sample strobe in the same cycle as the query does not affect that query's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_tick | input | 1 | Advance all oscillators one step |
| ld_valid | input | 1 | Load the oscillator named by ld_sel |
| ld_sel | input | 2 | 0,1 quadrature; 2,3 sawtooth |
| ld_rate | input | 16 | Rate (quadrature uses bits 8:0) |
| ld_amp | input | 15 | Quadrature amplitude, or span code in bits 1:0 |
| jam_valid | input | 1 | Restart a sawtooth |
| jam_sel | input | 1 | Sawtooth to restart |
| q_valid | input | 1 | Tap query strobe |
| q_sel | input | 2 | Oscillator queried |
| q_mod | input | 6 | Modifier bits |
| out_valid | output | 1 | Result strobe |
| out_addr | output | 16 | Signed delay offset |
| out_coef | output | 9 | Weight, 256 equals one |

## Verification
Every tap result is registered once, so a query driven before clock edge n is compared just after edge n, half a cycle later. Oscillator state changes at the edge where a strobe, load or restart is applied. The bench updates its arithmetic model at that same point, and the state is visible to the next query. For the same-cycle strobe-and-query case, the prediction is taken before the model advances. For the snapshot bit, the model captures the live value in the cycle the query is issued, matching the register write at that edge.

// File: rtl/lfo_pkg.sv
package lfo_pkg;
    localparam int SIN_W        = 16;
    localparam int SRATE_W      = 9;
    localparam int SAMP_W       = 15;
    localparam int RRATE_W      = 16;
    localparam int FRAC_W       = 8;
    localparam int SPAN_LOG_MIN = 9;
    localparam int SPAN_CODES   = 4;
    localparam int CODE_W       = $clog2(SPAN_CODES);
    localparam int RINT_W       = SPAN_LOG_MIN + SPAN_CODES - 1;
    localparam int PH_W         = RINT_W + FRAC_W;
    localparam int ADDR_W       = 16;
    localparam int COEF_W       = FRAC_W + 1;
    localparam int SIN_SHIFT    = 17;
    localparam int NUM_SIN      = 2;
    localparam int NUM_RMP      = 2;
    localparam int SEL_W        = $clog2(NUM_SIN + NUM_RMP);
    localparam int MOD_W        = 6;
    localparam int SIN_FRAC     = SIN_W - 1;

    localparam logic signed [SIN_W-1:0] SIN_INIT = SIN_W'(2**(SIN_W-1) - 2**(SIN_W-4));
    localparam logic [COEF_W-1:0] UNITY = COEF_W'(2**FRAC_W);

    typedef logic signed [SIN_W-1:0] osc_t;

    typedef struct packed {
        osc_t s;
        osc_t c;
    } quad_t;

    // modifier field, most significant bit first
    typedef struct packed {
        logic na;        // bit 5: crossfade gain, no offset
        logic half;      // bit 4: half-span second pointer
        logic inv_addr;  // bit 3: invert offset bits
        logic inv_coef;  // bit 2: complement weight
        logic grab;      // bit 1: use live state and snapshot it
        logic cosine;    // bit 0: cosine instead of sine
    } tapmod_t;

    function automatic quad_t quad_step(quad_t q, logic [SRATE_W-1:0] k);
        logic signed [SIN_W+SRATE_W:0] m1;
        logic signed [SIN_W+SRATE_W:0] m2;
        quad_t n;
        m1  = q.c * $signed({1'b0, k});
        n.s = q.s + osc_t'(m1 >>> SIN_SHIFT);
        m2  = n.s * $signed({1'b0, k});
        n.c = q.c - osc_t'(m2 >>> SIN_SHIFT);
        return n;
    endfunction

    function automatic logic [PH_W-1:0] span_mask(logic [CODE_W-1:0] code);
        return {PH_W{1'b1}} >> (CODE_W'(SPAN_CODES - 1) - code);
    endfunction

    function automatic logic [PH_W-1:0] half_span(logic [CODE_W-1:0] code);
        return (span_mask(code) >> 1) + PH_W'(1);
    endfunction

    function automatic int xf_shift(logic [CODE_W-1:0] code);
        return SPAN_LOG_MIN - 1 + int'(code);
    endfunction
endpackage

// File: rtl/lfo_sine_gen.sv
module lfo_sine_gen
    import lfo_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               load,
    input  logic [SRATE_W-1:0] rate_i,
    input  logic [SAMP_W-1:0]  amp_i,
    input  logic               snap,
    output quad_t              live_o,
    output quad_t              held_o,
    output logic [SAMP_W-1:0]  amp_o
);
    quad_t              q;
    quad_t              h;
    logic [SRATE_W-1:0] rate;
    logic [SAMP_W-1:0]  amp;

    always_ff @(posedge clk) begin
        if (rst) begin
            q    <= '0;
            h    <= '0;
            rate <= '0;
            amp  <= '0;
        end else begin
            if (load) begin
                q.s  <= '0;
                q.c  <= SIN_INIT;
                rate <= rate_i;
                amp  <= amp_i;
            end else if (tick) begin
                q <= quad_step(q, rate);
            end
            if (snap) h <= q;
        end
    end

    assign live_o = q;
    assign held_o = h;
    assign amp_o  = amp;

    a_r2_load_init: assert property (@(posedge clk) disable iff (rst)
        load |=> (q.s == '0 && q.c == SIN_INIT));

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!load && !tick) |=> $stable(q));
endmodule

// File: rtl/lfo_ramp_gen.sv
module lfo_ramp_gen
    import lfo_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               load,
    input  logic               jam,
    input  logic [RRATE_W-1:0] rate_i,
    input  logic [CODE_W-1:0]  code_i,
    input  logic               snap,
    output logic [PH_W-1:0]    live_o,
    output logic [PH_W-1:0]    held_o,
    output logic [CODE_W-1:0]  code_o
);
    logic [PH_W-1:0]    phase;
    logic [PH_W-1:0]    h;
    logic [RRATE_W-1:0] rate;
    logic [CODE_W-1:0]  code;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
            h     <= '0;
            rate  <= '0;
            code  <= '0;
        end else begin
            if (load) begin
                phase <= '0;
                rate  <= rate_i;
                code  <= code_i;
            end else if (jam) begin
                phase <= '0;
            end else if (tick) begin
                phase <= (phase - PH_W'(rate)) & span_mask(code);
            end
            if (snap) h <= phase;
        end
    end

    assign live_o = phase;
    assign held_o = h;
    assign code_o = code;

    a_r4_phase_in_span: assert property (@(posedge clk) disable iff (rst)
        phase <= span_mask(code));

    a_r11_jam_start: assert property (@(posedge clk) disable iff (rst)
        (jam && !load) |=> (phase == '0));
endmodule

// File: rtl/lfo_tap_shaper.sv
module lfo_tap_shaper
    import lfo_pkg::*;
(
    input  logic                     is_ramp,
    input  tapmod_t                  md,
    input  quad_t                    sc,
    input  logic [SAMP_W-1:0]        amp,
    input  logic [PH_W-1:0]          phase,
    input  logic [CODE_W-1:0]        code,
    output logic signed [ADDR_W-1:0] addr_o,
    output logic [COEF_W-1:0]        coef_o
);
    localparam int PROD_W = ADDR_W + SIN_FRAC;

    osc_t                      v;
    logic signed [PROD_W-1:0]  prod;
    logic [PH_W-1:0]           mask;
    logic [PH_W-1:0]           hs;
    logic [PH_W-1:0]           ph;
    logic [PH_W:0]             full;
    logic [PH_W:0]             tri_v;
    logic [ADDR_W-1:0]         a;
    logic [COEF_W-1:0]         k;

    always_comb begin
        v     = md.cosine ? sc.c : sc.s;
        prod  = v * $signed({1'b0, amp});
        mask  = span_mask(code);
        hs    = half_span(code);
        ph    = md.half ? ((phase + hs) & mask) : phase;
        full  = {1'b0, mask} + (PH_W+1)'(1);
        tri_v = (ph < hs) ? {1'b0, ph} : (full - {1'b0, ph});

        if (is_ramp) begin
            if (md.na) begin
                a = '0;
                k = COEF_W'(tri_v >> xf_shift(code));
            end else begin
                a = ADDR_W'(ph[PH_W-1:FRAC_W]);
                k = {1'b0, ph[FRAC_W-1:0]};
            end
        end else begin
            a = prod[PROD_W-1:SIN_FRAC];
            k = COEF_W'(prod[SIN_FRAC-1:0] >> (SIN_FRAC - FRAC_W));
        end

        if (md.inv_coef) k = UNITY - k;
        if (md.inv_addr && !(is_ramp && md.na)) a = ~a;

        addr_o = signed'(a);
        coef_o = k;
    end
endmodule

// File: rtl/lfo_addr_gen.sv
module lfo_addr_gen
    import lfo_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sample_tick,
    input  logic                     ld_valid,
    input  logic [SEL_W-1:0]         ld_sel,
    input  logic [RRATE_W-1:0]       ld_rate,
    input  logic [SAMP_W-1:0]        ld_amp,
    input  logic                     jam_valid,
    input  logic                     jam_sel,
    input  logic                     q_valid,
    input  logic [SEL_W-1:0]         q_sel,
    input  logic [MOD_W-1:0]         q_mod,
    output logic                     out_valid,
    output logic signed [ADDR_W-1:0] out_addr,
    output logic [COEF_W-1:0]        out_coef
);
    tapmod_t md;
    assign md = tapmod_t'(q_mod);

    quad_t             s_live [NUM_SIN];
    quad_t             s_held [NUM_SIN];
    logic [SAMP_W-1:0] s_amp  [NUM_SIN];
    logic [PH_W-1:0]   r_live [NUM_RMP];
    logic [PH_W-1:0]   r_held [NUM_RMP];
    logic [CODE_W-1:0] r_code [NUM_RMP];

    for (genvar i = 0; i < NUM_SIN; i++) begin : g_sin
        lfo_sine_gen u_sin (
            .clk    (clk),
            .rst    (rst),
            .tick   (sample_tick),
            .load   (ld_valid && ld_sel == SEL_W'(i)),
            .rate_i (ld_rate[SRATE_W-1:0]),
            .amp_i  (ld_amp),
            .snap   (q_valid && q_sel == SEL_W'(i) && md.grab),
            .live_o (s_live[i]),
            .held_o (s_held[i]),
            .amp_o  (s_amp[i])
        );
    end

    for (genvar j = 0; j < NUM_RMP; j++) begin : g_rmp
        lfo_ramp_gen u_rmp (
            .clk    (clk),
            .rst    (rst),
            .tick   (sample_tick),
            .load   (ld_valid && ld_sel == SEL_W'(NUM_SIN + j)),
            .jam    (jam_valid && jam_sel == 1'(j)),
            .rate_i (ld_rate),
            .code_i (ld_amp[CODE_W-1:0]),
            .snap   (q_valid && q_sel == SEL_W'(NUM_SIN + j) && md.grab),
            .live_o (r_live[j]),
            .held_o (r_held[j]),
            .code_o (r_code[j])
        );
    end

    // with two of each kind the low select bit picks the unit inside a kind
    logic                     is_ramp;
    logic                     unit;
    quad_t                    sc_sel;
    logic [PH_W-1:0]          ph_sel;
    logic signed [ADDR_W-1:0] tap_addr;
    logic [COEF_W-1:0]        tap_coef;

    always_comb begin
        is_ramp = (q_sel >= SEL_W'(NUM_SIN));
        unit    = q_sel[0];
        sc_sel  = md.grab ? s_live[unit] : s_held[unit];
        ph_sel  = md.grab ? r_live[unit] : r_held[unit];
    end

    lfo_tap_shaper u_shape (
        .is_ramp (is_ramp),
        .md      (md),
        .sc      (sc_sel),
        .amp     (s_amp[unit]),
        .phase   (ph_sel),
        .code    (r_code[unit]),
        .addr_o  (tap_addr),
        .coef_o  (tap_coef)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
            out_coef  <= '0;
        end else begin
            out_valid <= q_valid;
            if (q_valid) begin
                out_addr <= tap_addr;
                out_coef <= tap_coef;
            end
        end
    end

    a_r7_na_zero_addr: assert property (@(posedge clk) disable iff (rst)
        (q_valid && q_sel >= SEL_W'(NUM_SIN) && md.na) |=> (out_addr == '0));

    a_r8_coef_limit: assert property (@(posedge clk) disable iff (rst)
        out_coef <= UNITY);
endmodule

// File: tb/sim_lfo_addr_gen.sv
module sim_lfo_addr_gen;
    import lfo_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic               rst = 1'b1;
    logic               sample_tick = 1'b0;
    logic               ld_valid = 1'b0;
    logic [SEL_W-1:0]   ld_sel = '0;
    logic [RRATE_W-1:0] ld_rate = '0;
    logic [SAMP_W-1:0]  ld_amp = '0;
    logic               jam_valid = 1'b0;
    logic               jam_sel = 1'b0;
    logic               q_valid = 1'b0;
    logic [SEL_W-1:0]   q_sel = '0;
    logic [MOD_W-1:0]   q_mod = '0;
    logic               out_valid;
    logic signed [15:0] out_addr;
    logic [8:0]         out_coef;

    lfo_addr_gen u0 (.*);

    int n_run = 0;
    int n_fail = 0;

    // arithmetic model
    int ms [2], mc [2], mk [2], mamp [2], ls [2], lc [2];
    int mph [2], mrr [2], mcode [2], lph [2];

    function automatic int wrap16(int x);
        logic signed [15:0] t;
        t = x[15:0];
        return int'(t);
    endfunction

    task automatic model_step();
        for (int i = 0; i < 2; i++) begin
            int ns;
            ns = wrap16(ms[i] + ((mc[i] * mk[i]) >>> 17));
            mc[i] = wrap16(mc[i] - ((ns * mk[i]) >>> 17));
            ms[i] = ns;
        end
        for (int i = 0; i < 2; i++) begin
            int full;
            full = 131072 << mcode[i];
            mph[i] = mph[i] - mrr[i];
            if (mph[i] < 0) mph[i] = mph[i] + full;
        end
    endtask

    task automatic predict(input int g, input logic [5:0] m,
                           output logic signed [15:0] ea, output logic [8:0] ec);
        longint a;
        longint f;
        if (g < 2) begin
            int s, c, v;
            longint p;
            s = m[1] ? ms[g] : ls[g];
            c = m[1] ? mc[g] : lc[g];
            if (m[1]) begin ls[g] = ms[g]; lc[g] = mc[g]; end
            v = m[0] ? c : s;
            p = longint'(v) * longint'(mamp[g]);
            a = p >>> 15;
            f = (p & 64'sd32767) >>> 7;
        end else begin
            int r, ph, full, tv;
            r = g - 2;
            ph = m[1] ? mph[r] : lph[r];
            if (m[1]) lph[r] = mph[r];
            full = 131072 << mcode[r];
            if (m[4]) ph = (ph + full / 2) % full;
            if (m[5]) begin
                tv = (ph < full / 2) ? ph : full - ph;
                a = 0;
                f = longint'(tv) * 256 / (full / 2);
            end else begin
                a = ph / 256;
                f = ph % 256;
            end
        end
        ea = a[15:0];
        ec = f[8:0];
        if (m[2]) ec = 9'd256 - ec;
        if (m[3] && !(g >= 2 && m[5])) ea = ~ea;
    endtask

    task automatic chk(input string tag, input logic signed [15:0] aa, input logic signed [15:0] ea,
                       input logic [8:0] ac, input logic [8:0] ec);
        n_run++;
        if (aa !== ea || ac !== ec) begin
            n_fail++;
            $display("FAIL %s: addr=%0d coef=%0d expected addr=%0d coef=%0d", tag, aa, ac, ea, ec);
        end
    endtask

    function automatic string tag_of(int g, logic [5:0] m);
        if (g >= 2 && m[5]) return "R7";
        if (g >= 2 && m[4]) return "R6";
        if (g < 2 && m[5:4] != 2'b00) return "R12";
        if (m[3]) return "R9";
        if (m[2]) return "R8";
        if (m[1]) return "R10";
        if (g >= 2) return "R5";
        return "R3";
    endfunction

    task automatic query(input int g, input logic [5:0] m, input string tag);
        logic signed [15:0] ea;
        logic [8:0] ec;
        @(negedge clk);
        q_valid = 1'b1; q_sel = SEL_W'(g); q_mod = m;
        predict(g, m, ea, ec);
        @(negedge clk);
        q_valid = 1'b0;
        chk(tag, out_addr, ea, out_coef, ec);
    endtask

    task automatic tick();
        @(negedge clk); sample_tick = 1'b1;
        @(negedge clk); sample_tick = 1'b0;
        model_step();
    endtask

    task automatic load(input int g, input int rate, input int amp);
        @(negedge clk);
        ld_valid = 1'b1; ld_sel = SEL_W'(g); ld_rate = 16'(rate); ld_amp = 15'(amp);
        @(negedge clk);
        ld_valid = 1'b0;
        if (g < 2) begin
            ms[g] = 0; mc[g] = 28672; mk[g] = rate & 511; mamp[g] = amp;
        end else begin
            mph[g-2] = 0; mrr[g-2] = rate & 65535; mcode[g-2] = amp & 3;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 2; i++) begin
            ms[i] = 0; mc[i] = 0; mk[i] = 0; mamp[i] = 0; ls[i] = 0; lc[i] = 0;
            mph[i] = 0; mrr[i] = 0; mcode[i] = 0; lph[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        n_run++;
        if (out_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: out_valid=%0d expected 0", out_valid);
        end
        chk("R1", out_addr, 16'sd0, out_coef, 9'd0);
        for (int g = 0; g < 4; g++) query(g, 6'd0, "R1");

        // near-exhaustive sweep: every modifier on every oscillator, every span code
        for (int c = 0; c < 4; c++) begin
            load(0, 511, 20000);              // R2
            load(1, 97, 32767);
            load(2, 9000 + c * 700, c);       // R4
            load(3, 23456, 3 - c);
            for (int step = 0; step < 24; step++) begin
                repeat (4) tick();
                for (int g = 0; g < 4; g++)
                    for (int m = 0; m < 64; m++)
                        query(g, 6'(m), tag_of(g, 6'(m)));
            end
        end

        // R11 restart of sawtooth 0, sawtooth 1 untouched
        tick();
        @(negedge clk); jam_valid = 1'b1; jam_sel = 1'b0;
        @(negedge clk); jam_valid = 1'b0;
        mph[0] = 0;
        query(2, 6'b000010, "R11");
        query(3, 6'b000010, "R11");

        // R11 restart wins over a simultaneous step; the other sawtooth still steps
        @(negedge clk); jam_valid = 1'b1; jam_sel = 1'b1; sample_tick = 1'b1;
        @(negedge clk); jam_valid = 1'b0; sample_tick = 1'b0;
        model_step();
        mph[1] = 0;
        query(3, 6'b000010, "R11");
        query(2, 6'b000010, "R11");

        // R2 load wins over a simultaneous step
        @(negedge clk);
        ld_valid = 1'b1; ld_sel = 2'd1; ld_rate = 16'd200; ld_amp = 15'd16384; sample_tick = 1'b1;
        @(negedge clk); ld_valid = 1'b0; sample_tick = 1'b0;
        model_step();
        ms[1] = 0; mc[1] = 28672; mk[1] = 200; mamp[1] = 16384;
        query(1, 6'b000011, "R2");

        // R13 a step in the query cycle does not affect that result
        begin
            logic signed [15:0] ea;
            logic [8:0] ec;
            @(negedge clk);
            q_valid = 1'b1; q_sel = 2'd2; q_mod = 6'b000010; sample_tick = 1'b1;
            predict(2, 6'b000010, ea, ec);
            @(negedge clk);
            q_valid = 1'b0; sample_tick = 1'b0;
            model_step();
            chk("R13", out_addr, ea, out_coef, ec);
            n_run++;
            if (out_valid !== 1'b1) begin
                n_fail++;
                $display("FAIL R13: out_valid=%0d expected 1", out_valid);
            end
            @(negedge clk);
            n_run++;
            if (out_valid !== 1'b0) begin
                n_fail++;
                $display("FAIL R13: out_valid=%0d expected 0", out_valid);
            end
            query(2, 6'b000010, "R13");
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule